// File: doc/BRIEF.md
# Reset Sequencer with Mode Sampling

This block produces the system-wide internal reset. There are two sources. The first is an active-low reset pin, which pulls the internal reset low at once, with no clock edge needed. That reset is let go only through a synchroniser clocked by the master clock. The second is a single-cycle request from a watchdog, which holds the internal reset low for a fixed number of cycles. After either kind of release, a processor fetch enable stays off for a fixed number of clocks. A gated copy of the master clock is held low while the pin is asserted and runs freely at all other times.

While the pin holds the chip in reset, two configuration pins are recorded into a short history:
- a boot-width select;
- an active-low output-disable request.

When the pin is released, the samples from the last few clock edges before the rising edge decide the two mode outputs. A mode is taken from its pin only if the pin held one level through the whole window. If it did not, the mode falls back to a safe default. A watchdog reset leaves both modes as they are. A one-bit cause output tells software whether the most recent reset came from the pin or from the watchdog.

Top module: `rst_seq`

## Requirements
- R1: When `ext_rst_n` goes low, `sys_rst_n` and `fetch_en` go low at once, with no clock edge needed, and stay low while the pin is low.
- R2: After `ext_rst_n` rises between two clock edges, `sys_rst_n` is still low after the first following rising edge and goes high after the second (SYNC_STAGES = 2).
- R3: `fetch_en` rises after the FETCH_DLY-th rising edge (80) after the pin rises. It is low whenever `sys_rst_n` is low.
- R4: While the pin is low, `boot_mode` = 1 and `drv_off` = 0. The new modes are taken from the pin samples at the last WIN (10) rising edges before the pin rises. They are visible after the third edge following the release.
- R5: If the window is stable, `boot_mode` equals the `boot_pin` level (1 = 8-bit boot memory, 0 = 16-bit). `drv_off` = 1 exactly when `tri_pin_n` was low in every window sample.
- R6: If a pin takes two different values inside the window, its mode takes the default (`boot_mode` = 1, `drv_off` = 0). A glitch at the edge just before the window has no effect.
- R7: If `wdog_req` is high at a rising edge while `sys_rst_n` is high, `sys_rst_n` is low for WD_HOLD (4) cycles after that edge. `fetch_en` then rises FETCH_DLY − SYNC_STAGES (78) edges after `sys_rst_n` rises again.
- R8: A watchdog reset leaves `boot_mode` and `drv_off` unchanged. Pin activity during a watchdog reset has no effect on them.
- R9: The pin has priority. A `wdog_req` that arrives while the pin is low is ignored: `rst_cause` stays 0 and the release timing of R2 and R3 is unchanged.
- R10: `rst_cause` is 0 from a pin reset onward and 1 from an accepted watchdog request onward.
- R11: `clk_out` is low while the pin is low. It first follows `clk` in the high phase after the third edge following the release. It keeps toggling during a watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_req | input | 1 | Watchdog reset request, sampled on rising edges |
| boot_pin | input | 1 | Boot-width select pin (1 = 8-bit, 0 = 16-bit) |
| tri_pin_n | input | 1 | Output-disable request pin, active low |
| sys_rst_n | output | 1 | Internal system reset, active low |
| fetch_en | output | 1 | Processor fetch permission |
| clk_out | output | 1 | Gated copy of the master clock |
| boot_mode | output | 1 | Latched boot-width mode |
| drv_off | output | 1 | Latched output-driver disable |
| rst_cause | output | 1 | Cause of the last reset: 0 = pin, 1 = watchdog |

## Verification
The mode capture is swept over all four pin-level pairs. Each pair is run with no glitch, and with a one-cycle glitch on either pin at three positions:
- the edge just before the window, which shows where the window starts;
- the first edge of the window;
- the last edge before release, which shows the window does not reach into the synchroniser delay.

Every boot also counts, edge by edge, when `sys_rst_n`, `clk_out` and `fetch_en` first come up. Separate runs then trigger a watchdog reset while the pins change, and send watchdog requests while the pin is held low, to tell mode retention and pin priority apart from a pin reset.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic {
        CAUSE_PIN  = 1'b0,
        CAUSE_WDOG = 1'b1
    } rst_cause_e;

endpackage

// File: rtl/rst_seq_sync.sv
// Reset synchroniser: asynchronous assertion, release after STAGES edges.
module rst_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= (chain_q << 1) | STAGES'(1);
        end
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rst_seq_window.sv
// Per-pin delay pipe and sample history.
// The history shifts only while shift_en is high.
// The flops carry no reset, because they must record during reset.
module rst_seq_window #(
    parameter int NPIN  = 2,
    parameter int DELAY = 2,
    parameter int WIN   = 10
) (
    input  logic            clk,
    input  logic            shift_en,
    input  logic [NPIN-1:0] pins,
    output logic [NPIN-1:0] newest,
    output logic [NPIN-1:0] stable
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [DELAY-1:0] pipe_q;
        logic [WIN-1:0]   hist_q;

        always_ff @(posedge clk) begin
            pipe_q <= (pipe_q << 1) | DELAY'(pins[g]);
            if (shift_en) begin
                hist_q <= (hist_q << 1) | WIN'(pipe_q[DELAY-1]);
            end
        end

        assign newest[g] = hist_q[0];
        assign stable[g] = (&hist_q) | ~(|hist_q);
    end
endmodule

// File: rtl/rst_seq_clkgate.sv
// Clock-output gate.
// The enable is updated on the falling edge, so the output cannot glitch.
module rst_seq_clkgate (
    input  logic clk,
    input  logic arst_n,
    input  logic en_in,
    output logic clk_out
);
    logic en_q;

    always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_in;
        end
    end

    assign clk_out = clk & en_q;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rst_seq_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   WIN_LEN     = 10,
    parameter int   FETCH_DLY   = 80,
    parameter int   WD_HOLD     = 4,
    parameter logic BOOT_DEF    = 1'b1
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic wdog_req,
    input  logic boot_pin,
    input  logic tri_pin_n,
    output logic sys_rst_n,
    output logic fetch_en,
    output logic clk_out,
    output logic boot_mode,
    output logic drv_off,
    output logic rst_cause
);
    localparam int CNT_W      = $clog2(FETCH_DLY + 1);
    localparam int WD_W       = $clog2(WD_HOLD + 1);
    localparam int FETCH_LAST = FETCH_DLY - SYNC_STAGES - 1;

    typedef struct packed {
        logic             rel_seen;
        logic             wd_active;
        logic [WD_W-1:0]  wd_cnt;
        logic [CNT_W-1:0] fetch_cnt;
        logic             fetch_done;
        logic             boot;
        logic             drv_off;
        rst_cause_e       cause;
    } state_t;

    localparam state_t RST_VAL = '{
        rel_seen:   1'b0,
        wd_active:  1'b0,
        wd_cnt:     '0,
        fetch_cnt:  '0,
        fetch_done: 1'b0,
        boot:       BOOT_DEF,
        drv_off:    1'b0,
        cause:      CAUSE_PIN
    };

    state_t     q, d;
    logic       pin_ok;
    logic       run;
    logic       win_shift;
    logic [1:0] win_new;
    logic [1:0] win_stable;

    rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .sync_n (pin_ok)
    );

    assign win_shift = ~pin_ok;

    // Pin 0: boot width, pin 1: output-disable request.
    rst_seq_window #(.NPIN(2), .DELAY(SYNC_STAGES), .WIN(WIN_LEN)) u_win (
        .clk      (clk),
        .shift_en (win_shift),
        .pins     ({tri_pin_n, boot_pin}),
        .newest   (win_new),
        .stable   (win_stable)
    );

    rst_seq_clkgate u_gate (
        .clk     (clk),
        .arst_n  (ext_rst_n),
        .en_in   (pin_ok),
        .clk_out (clk_out)
    );

    assign run = pin_ok & ~q.wd_active;

    always_comb begin
        d          = q;
        d.rel_seen = pin_ok;

        // Capture the modes once, on the first cycle after the pin release.
        if (pin_ok && !q.rel_seen) begin
            d.boot    = win_stable[0] ? win_new[0]  : BOOT_DEF;
            d.drv_off = win_stable[1] ? !win_new[1] : 1'b0;
        end

        // Watchdog reset stretch.
        if (q.wd_active) begin
            if (q.wd_cnt == WD_W'(WD_HOLD - 1)) begin
                d.wd_active = 1'b0;
                d.wd_cnt    = '0;
            end else begin
                d.wd_cnt = q.wd_cnt + 1'b1;
            end
        end else if (wdog_req && pin_ok) begin
            d.wd_active = 1'b1;
            d.wd_cnt    = '0;
            d.cause     = CAUSE_WDOG;
        end

        // Fetch delay.
        if (!run) begin
            d.fetch_cnt  = '0;
            d.fetch_done = 1'b0;
        end else if (!q.fetch_done) begin
            if (q.fetch_cnt == CNT_W'(FETCH_LAST)) begin
                d.fetch_done = 1'b1;
            end else begin
                d.fetch_cnt = q.fetch_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign sys_rst_n = run;
    assign fetch_en  = q.fetch_done & run;
    assign boot_mode = q.boot;
    assign drv_off   = q.drv_off;
    assign rst_cause = q.cause;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
    input logic clk,
    input logic ext_rst_n,
    input logic sys_rst_n,
    input logic fetch_en,
    input logic boot_mode,
    input logic drv_off,
    input logic rst_cause
);
    always @(negedge clk) begin
        if (!ext_rst_n) begin
            // R1
            sys_async_chk: assert (!sys_rst_n && !fetch_en);
        end
    end

    // R3
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !sys_rst_n |-> !fetch_en);

    // R3
    fetch_keep_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (fetch_en && sys_rst_n) |=> (fetch_en || !sys_rst_n));

    // R8
    mode_keep_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $past(sys_rst_n, 2) |-> ($stable(boot_mode) && $stable(drv_off)));

    // R10
    cause_set_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(rst_cause) |-> !sys_rst_n);
endmodule

bind rst_seq rst_seq_chk u_chk (
    .clk       (clk),
    .ext_rst_n (ext_rst_n),
    .sys_rst_n (sys_rst_n),
    .fetch_en  (fetch_en),
    .boot_mode (boot_mode),
    .drv_off   (drv_off),
    .rst_cause (rst_cause)
);

// File: tb/rst_seq_tb_top.sv
`timescale 1ns/1ps
module rst_seq_tb_top;
    localparam int SYNC  = 2;
    localparam int WIN   = 10;
    localparam int FDLY  = 80;
    localparam int WHOLD = 4;
    localparam int HOLD  = 14;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0;
    logic wdog_req = 1'b0;
    logic boot_pin = 1'b1;
    logic tri_pin_n = 1'b1;
    logic sys_rst_n, fetch_en, clk_out, boot_mode, drv_off, rst_cause;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rst_seq #(.SYNC_STAGES(SYNC), .WIN_LEN(WIN), .FETCH_DLY(FDLY),
              .WD_HOLD(WHOLD), .BOOT_DEF(1'b1)) dut_i (
        .clk(clk), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
        .boot_pin(boot_pin), .tri_pin_n(tri_pin_n), .sys_rst_n(sys_rst_n),
        .fetch_en(fetch_en), .clk_out(clk_out), .boot_mode(boot_mode),
        .drv_off(drv_off), .rst_cause(rst_cause));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    // gpin: 0 = boot pin, 1 = tri pin, -1 = none. gidx: sample edge index to glitch.
    task automatic pin_boot(input bit bv, input bit tn, input int gpin, input int gidx,
                            input bit wd_during);
        int  sys_first = 0;
        int  clk_first = 0;
        int  fet_first = 0;
        bit  inwin;
        bit  exp_boot;
        bit  exp_drv;
        ext_rst_n = 1'b0;
        wdog_req  = wd_during;
        boot_pin  = (gpin == 0 && gidx == 0) ? ~bv : bv;
        tri_pin_n = (gpin == 1 && gidx == 0) ? ~tn : tn;
        #1;
        check("R1 sys_rst_n async low", int'(sys_rst_n), 0);
        check("R1 fetch_en async low", int'(fetch_en), 0);
        for (int i = 0; i < HOLD; i++) begin
            step();
            boot_pin  = (gpin == 0 && gidx == i + 1) ? ~bv : bv;
            tri_pin_n = (gpin == 1 && gidx == i + 1) ? ~tn : tn;
            if (i == 2) begin
                check("R4 default boot_mode in reset", int'(boot_mode), 1);
                check("R4 default drv_off in reset", int'(drv_off), 0);
                check("R11 clk_out low in reset", int'(clk_out), 0);
                check("R10 cause pin in reset", int'(rst_cause), 0);
            end
        end
        ext_rst_n = 1'b1;
        wdog_req  = 1'b0;
        inwin    = (gidx >= HOLD - WIN) && (gidx <= HOLD - 1);
        exp_boot = (gpin == 0 && inwin) ? 1'b1 : bv;
        exp_drv  = (gpin == 1 && inwin) ? 1'b0 : !tn;
        for (int n = 1; n <= FDLY + 4; n++) begin
            step();
            if (sys_rst_n && sys_first == 0) sys_first = n;
            if (clk_out && clk_first == 0) clk_first = n;
            if (fetch_en && fet_first == 0) fet_first = n;
            if (n == 3) begin
                check(gpin < 0 ? "R5 boot_mode stable" : "R6 boot_mode glitch",
                      int'(boot_mode), int'(exp_boot));
                check(gpin < 0 ? "R5 drv_off stable" : "R6 drv_off glitch",
                      int'(drv_off), int'(exp_drv));
            end
        end
        check(wd_during ? "R9 release edge with wdog" : "R2 release edge", sys_first, SYNC);
        check("R11 clk_out first high", clk_first, SYNC + 1);
        check(wd_during ? "R9 fetch edge with wdog" : "R3 fetch edge", fet_first, FDLY);
        check(wd_during ? "R9 cause stays pin" : "R10 cause pin", int'(rst_cause), 0);
    endtask

    initial begin
        int sys_first;
        int fet_first;
        bit mode_bad;
        step();
        // R4 R5 R6: sweep pin levels with glitch positions.
        for (int bv = 0; bv < 2; bv++) begin
            for (int tn = 0; tn < 2; tn++) begin
                pin_boot(bv[0], tn[0], -1, -1, 1'b0);
                for (int gp = 0; gp < 2; gp++) begin
                    pin_boot(bv[0], tn[0], gp, HOLD - WIN - 1, 1'b0);
                    pin_boot(bv[0], tn[0], gp, HOLD - WIN, 1'b0);
                    pin_boot(bv[0], tn[0], gp, HOLD - 1, 1'b0);
                end
            end
        end
        // R9: watchdog request while the pin is low.
        pin_boot(1'b0, 1'b1, -1, -1, 1'b1);

        // R7 R8 R10 R11: watchdog reset after a boot with boot=0, drv_off=1.
        pin_boot(1'b0, 1'b0, -1, -1, 1'b0);
        step();
        wdog_req = 1'b1;
        step();
        wdog_req = 1'b0;
        check("R7 sys_rst_n low after wdog", int'(sys_rst_n), 0);
        check("R7 fetch_en low after wdog", int'(fetch_en), 0);
        check("R10 cause wdog", int'(rst_cause), 1);
        check("R11 clk_out runs in wdog reset", int'(clk_out), 1);
        boot_pin  = 1'b1;
        tri_pin_n = 1'b1;
        sys_first = 0;
        fet_first = 0;
        mode_bad  = 1'b0;
        for (int k = 1; k <= FDLY + 10; k++) begin
            step();
            if (k == 2) begin
                boot_pin  = 1'b0;
                tri_pin_n = 1'b0;
            end
            if (k == 3) begin
                boot_pin  = 1'b1;
                tri_pin_n = 1'b1;
            end
            if (sys_rst_n && sys_first == 0) sys_first = k;
            if (fetch_en && fet_first == 0) fet_first = k;
            if (boot_mode != 1'b0 || drv_off != 1'b1) mode_bad = 1'b1;
        end
        check("R7 wdog hold length", sys_first, WHOLD);
        check("R7 fetch after wdog", fet_first, WHOLD + FDLY - SYNC);
        check("R8 modes kept over wdog", int'(mode_bad), 0);
        check("R10 cause still wdog", int'(rst_cause), 1);

        // R10: a pin reset returns the cause to pin.
        pin_boot(1'b1, 1'b1, -1, -1, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule